// File: doc/BRIEF.md
# Interval Timer Counter Channel

A single down-counting timer channel with a 16-bit count register and six operating modes. A register front end (not part of this block) hands the channel a count value and a 3-bit mode code with a one-cycle load strobe. A count-clock enable (`tick_i`) advances the channel, and a gate input either pauses counting or retriggers it, depending on the mode. The channel drives one output line and a live 16-bit current-count value for readback.

The channel's behaviour is defined in terms of the elapsed tick count `d` since the last load or retrigger, and the loaded count `N`. A loaded value of zero means `N` = 65536. For each mode, the output level and the readback value are fixed functions of `d` and `N`. BCD counting is not supported, and count values are always taken as binary.

Top module: `ivt_channel`

## Requirements
- R1: After reset the channel is idle until the first load. In this state `out_o` is 0, `count_o` reads 0 (a count of 65536), and ticks and gate activity have no effect.
- R2: In the cycle after a load strobe, `count_o` equals the loaded 16-bit value in every mode. A loaded value of 0 is taken as a count of 65536 and reads back as 0.
- R3: A load, or a retrigger, clears `d` to 0. The next effective tick after it is absorbed and does not advance `d`. Each later effective tick adds one to `d`.
- R4: Mode code 0: `out_o` is 0 while `d` < `N` and 1 once `d` >= `N`. `count_o` is (`N` - `d`) mod 65536.
- R5: Mode code 1: `out_o` is 0 while `d` < `N` and 1 afterwards. `count_o` is (`N` - `d`) mod 65536.
- R6: Mode code 2: `out_o` is 1 only while `d` is a nonzero multiple of `N`. `count_o` is `N` - (`d` mod `N`), which reloads periodically.
- R7: Mode code 3: `out_o` is 1 while (`d` mod `N`) < ceil(`N`/2). `count_o` is `N` - ((2·`d`) mod `N`), so it steps down by two per tick.
- R8: Mode codes 4 and 5: `out_o` is 1 only while `d` equals `N`. `count_o` is (`N` - `d`) mod 65536.
- R9: In mode codes 0 and 4, a tick while `gate_i` is 0 has no effect. `count_o` and `out_o` hold.
- R10: In mode codes 1, 2, 3 and 5, a rising edge on `gate_i` retriggers the channel. `count_o` returns to `N` in the next cycle. The gate level does not otherwise stop counting.
- R11: In mode codes 0, 1, 4 and 5, `count_o` wraps from 0 to 65535 and keeps counting down.
- R12: Mode codes 6 and 7 behave exactly as mode codes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable; one tick per cycle in which it is high |
| gate_i | input | 1 | Gate level |
| load_i | input | 1 | Load strobe for count and mode |
| load_val_i | input | 16 | Count value; 0 means 65536 |
| mode_i | input | 3 | Mode code, captured with `load_i` |
| out_o | output | 1 | Timer output line |
| count_o | output | 16 | Live current count |

## Verification
The hardest cases to reach are those where `d` no longer matches the count of ticks that occurred. These arise when a gate pause in modes 0 and 4 overlaps the absorbed first tick, or when a gate retrigger in the edge modes falls partway through a period. The sweep produces them by running every mode code against several small counts and against 65536. It uses an irregular tick pattern and a gate that drops and rises on a period that does not divide the tick pattern. A bench-side model tracks `d` directly and evaluates the per-mode formulas every cycle.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef enum logic [2:0] {
    M_TERM    = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6/7 alias rate and square
  function automatic mode_e fold_mode(input logic [2:0] code);
    return (code[2] & code[1]) ? mode_e'({1'b0, code[1:0]}) : mode_e'(code);
  endfunction

  function automatic logic is_edge_mode(input mode_e m);
    return (m == M_ONESHOT) || (m == M_RATE) || (m == M_SQUARE) || (m == M_HWSTB);
  endfunction
endpackage

// File: rtl/ivt_gate_ctl.sv
module ivt_gate_ctl
  import ivt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  tick_i,
  input  logic  gate_i,
  input  logic  load_i,
  input  logic  armed_i,
  input  mode_e mode_i,
  output logic  gate_rise_o,
  output logic  restart_o,
  output logic  step_o
);
  logic gate_q, pend_q, enable, advance;

  assign gate_rise_o = gate_i & ~gate_q;
  assign restart_o   = load_i | (armed_i & gate_rise_o & is_edge_mode(mode_i));
  assign enable      = is_edge_mode(mode_i) ? 1'b1 : gate_i;
  assign advance     = armed_i & tick_i & enable & ~restart_o;
  assign step_o      = advance & ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      if (restart_o)    pend_q <= 1'b1;
      else if (advance) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ivt_phase.sv
module ivt_phase #(
  parameter  int CW = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  input  logic [NW-1:0] limit_i,
  output logic [NW-1:0] phase_o,
  output logic [NW-1:0] dbl_o,
  output logic [CW-1:0] wrap_o,
  output logic          done_o,
  output logic          hit_o,
  output logic          started_o
);
  logic [NW-1:0] phase_q, dbl_q, ph_inc, ph_nxt, dbl_nxt;
  logic [NW:0]   dbl_inc, lim1, lim2;
  logic [CW-1:0] wrap_q;
  logic          done_q, hit_q, started_q, hit_nxt;

  assign ph_inc  = phase_q + NW'(1);
  assign ph_nxt  = (ph_inc == limit_i) ? '0 : ph_inc;
  assign lim1    = {1'b0, limit_i};
  assign lim2    = {limit_i, 1'b0};
  assign dbl_inc = {1'b0, dbl_q} + (NW+1)'(2);

  always_comb begin
    if (dbl_inc >= lim2)      dbl_nxt = NW'(dbl_inc - lim2);
    else if (dbl_inc >= lim1) dbl_nxt = NW'(dbl_inc - lim1);
    else                      dbl_nxt = NW'(dbl_inc);
  end

  assign hit_nxt = ~done_q & (wrap_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      dbl_q     <= '0;
      wrap_q    <= '0;
      done_q    <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (restart_i) begin
      phase_q   <= '0;
      dbl_q     <= '0;
      wrap_q    <= limit_i[CW-1:0];
      done_q    <= 1'b0;
      hit_q     <= 1'b0;
      started_q <= 1'b0;
    end else if (step_i) begin
      phase_q   <= ph_nxt;
      dbl_q     <= dbl_nxt;
      wrap_q    <= wrap_q - CW'(1);
      done_q    <= done_q | hit_nxt;
      hit_q     <= hit_nxt;
      started_q <= 1'b1;
    end
  end

  assign phase_o   = phase_q;
  assign dbl_o     = dbl_q;
  assign wrap_o    = wrap_q;
  assign done_o    = done_q;
  assign hit_o     = hit_q;
  assign started_o = started_q;
endmodule

// File: rtl/ivt_outsel.sv
module ivt_outsel
  import ivt_pkg::*;
#(
  parameter  int CW = 16,
  localparam int NW = CW + 1
) (
  input  mode_e         mode_i,
  input  logic          armed_i,
  input  logic [NW-1:0] limit_i,
  input  logic [NW-1:0] phase_i,
  input  logic [NW-1:0] dbl_i,
  input  logic [CW-1:0] wrap_i,
  input  logic          done_i,
  input  logic          hit_i,
  input  logic          started_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  logic [NW:0]   half;
  logic [NW-1:0] rate_cnt, sq_cnt;

  assign half     = ({1'b0, limit_i} + (NW+1)'(1)) >> 1;
  assign rate_cnt = limit_i - phase_i;
  assign sq_cnt   = limit_i - dbl_i;

  always_comb begin
    out_o   = 1'b0;
    count_o = '0;
    if (armed_i) begin
      unique case (mode_i)
        M_TERM, M_ONESHOT: begin out_o = done_i; count_o = wrap_i; end
        M_RATE:   begin out_o = started_i & (phase_i == '0); count_o = rate_cnt[CW-1:0]; end
        M_SQUARE: begin out_o = ({1'b0, phase_i} < half); count_o = sq_cnt[CW-1:0]; end
        default:  begin out_o = hit_i; count_o = wrap_i; end
      endcase
    end
  end
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter  int CW = 16,
  localparam int NW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [2:0]    mode_i,
  output logic          out_o,
  output logic [CW-1:0] count_o
);
  localparam logic [NW-1:0] FULL = NW'(1) << CW;

  mode_e         mode_q;
  logic          armed_q;
  logic [NW-1:0] limit_q, limit_nxt, phase, dbl;
  logic [CW-1:0] wrap;
  logic          gate_rise, restart, step, done, hit, started;

  assign limit_nxt = load_i ? ((load_val_i == '0) ? FULL : {1'b0, load_val_i}) : limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= M_TERM;
      armed_q <= 1'b0;
      limit_q <= FULL;
    end else if (load_i) begin
      mode_q  <= fold_mode(mode_i);
      armed_q <= 1'b1;
      limit_q <= limit_nxt;
    end
  end

  ivt_gate_ctl u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .gate_i      (gate_i),
    .load_i      (load_i),
    .armed_i     (armed_q),
    .mode_i      (mode_q),
    .gate_rise_o (gate_rise),
    .restart_o   (restart),
    .step_o      (step)
  );

  ivt_phase #(.CW(CW)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (step),
    .limit_i   (limit_nxt),
    .phase_o   (phase),
    .dbl_o     (dbl),
    .wrap_o    (wrap),
    .done_o    (done),
    .hit_o     (hit),
    .started_o (started)
  );

  ivt_outsel #(.CW(CW)) u_out (
    .mode_i    (mode_q),
    .armed_i   (armed_q),
    .limit_i   (limit_q),
    .phase_i   (phase),
    .dbl_i     (dbl),
    .wrap_i    (wrap),
    .done_i    (done),
    .hit_i     (hit),
    .started_i (started),
    .out_o     (out_o),
    .count_o   (count_o)
  );
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk
  import ivt_pkg::*;
#(
  parameter  int CW = 16,
  localparam int NW = CW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          gate_i,
  input logic          load_i,
  input logic [CW-1:0] load_val_i,
  input logic [2:0]    mode_i,
  input logic          out_o,
  input logic [CW-1:0] count_o,
  input logic          armed,
  input logic          gate_rise,
  input mode_e         mode_q,
  input logic [NW-1:0] limit_q
);
  a_r1_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> (!out_o && count_o == '0));

  a_r2_load_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));

  a_r4_load_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && fold_mode(mode_i) == M_TERM) |=> !out_o);

  a_r3_no_tick_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !gate_rise) |=> ($stable(count_o) && $stable(out_o)));

  a_r9_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !load_i && !gate_i && (mode_q == M_TERM || mode_q == M_SWSTB))
      |=> ($stable(count_o) && $stable(out_o)));

  a_r10_retrigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && !load_i && gate_rise && is_edge_mode(mode_q))
      |=> count_o == $past(limit_q[CW-1:0]));
endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .gate_i     (gate_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .mode_i     (mode_i),
  .out_o      (out_o),
  .count_o    (count_o),
  .armed      (armed_q),
  .gate_rise  (gate_rise),
  .mode_q     (mode_q),
  .limit_q    (limit_q)
);

// File: tb/ivt_channel_tb.sv
`timescale 1ns/1ps
module ivt_channel_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, gate = 1'b0, load = 1'b0;
  logic [15:0] val = '0;
  logic [2:0]  mode = '0;
  logic        out;
  logic [15:0] cnt;

  int checks = 0, errors = 0;
  longint d = 0, n = 65536;
  int  md = 0;
  bit  armed = 0, pend = 0, gq = 0;

  always #2.5 clk = ~clk;

  ivt_channel u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .gate_i(gate), .load_i(load),
    .load_val_i(val), .mode_i(mode), .out_o(out), .count_o(cnt)
  );

  task automatic model_update();
    bit rise = gate & ~gq;
    bit edge_m;
    gq = gate;
    if (!armed && !load) return;
    if (load) begin
      n = (val == 0) ? 65536 : longint'(val);
      md = (mode > 5) ? int'(mode) - 4 : int'(mode);
      armed = 1; d = 0; pend = 1;
      return;
    end
    edge_m = (md == 1 || md == 2 || md == 3 || md == 5);
    if (rise && edge_m) begin d = 0; pend = 1; end
    else if (tick && (edge_m || gate)) begin
      if (pend) pend = 0; else d++;
    end
  endtask

  task automatic check(input string tag);
    bit eo; longint ec;
    if (!armed) begin eo = 0; ec = 0; end
    else case (md)
      0, 1: begin eo = (d >= n); ec = (n - d) & 16'hffff; end
      2: begin eo = ((d % n) == 0) && (d != 0); ec = (n - (d % n)) & 16'hffff; end
      3: begin eo = ((d % n) < ((n + 1) / 2)); ec = (n - ((2 * d) % n)) & 16'hffff; end
      default: begin eo = (d == n); ec = (n - d) & 16'hffff; end
    endcase
    checks++;
    if (out !== eo || cnt !== 16'(ec)) begin
      errors++;
      $display("FAIL %s: out=%0b cnt=%0d expected out=%0b cnt=%0d (d=%0d n=%0d)",
               tag, out, cnt, eo, ec, d, n);
    end
  endtask

  task automatic drive(input bit t, input bit g, input bit l, input logic [15:0] v,
                       input logic [2:0] m, input string tag);
    @(negedge clk);
    tick = t; gate = g; load = l; val = v; mode = m;
    @(posedge clk);
    model_update();
    #1;
    check(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 reset");
    // R1: activity before a load does nothing
    for (int k = 0; k < 6; k++) drive(1, k[0], 0, 16'h0, 3'd2, "R1 idle");

    // R2: load value readback, zero as 65536
    drive(0, 1, 1, 16'h1234, 3'd1, "R2 load");
    drive(0, 1, 1, 16'h0000, 3'd2, "R2 zero");

    // R3: first tick after load absorbed
    drive(0, 1, 1, 16'd6, 3'd0, "R3 load");
    drive(1, 1, 0, 16'd0, 3'd0, "R3 absorbed");
    drive(1, 1, 0, 16'd0, 3'd0, "R3 first step");

    // R9: gate low pauses mode 0
    drive(0, 1, 1, 16'd5, 3'd0, "R9 load");
    drive(1, 1, 0, 16'd0, 3'd0, "R9 run");
    drive(1, 1, 0, 16'd0, 3'd0, "R9 run");
    for (int k = 0; k < 3; k++) drive(1, 0, 0, 16'd0, 3'd0, "R9 gate low hold");

    // R10: gate rise restarts mode 1
    drive(0, 1, 1, 16'd8, 3'd1, "R10 load");
    for (int k = 0; k < 5; k++) drive(1, 1, 0, 16'd0, 3'd1, "R10 run");
    drive(0, 0, 0, 16'd0, 3'd1, "R10 gate low");
    drive(0, 1, 0, 16'd0, 3'd1, "R10 retrigger");

    // R11: wrap below zero in mode 4
    drive(0, 1, 1, 16'd2, 3'd4, "R11 load");
    for (int k = 0; k < 5; k++) drive(1, 1, 0, 16'd0, 3'd4, "R11 wrap");

    // sweep: every mode code, several counts, irregular tick and gate
    for (int code = 0; code < 8; code++) begin
      for (int ni = 0; ni < 8; ni++) begin
        logic [15:0] nv;
        int len;
        string tag;
        case (ni)
          0: nv = 1; 1: nv = 2; 2: nv = 3; 3: nv = 4;
          4: nv = 5; 5: nv = 7; 6: nv = 10; default: nv = 0;
        endcase
        case (code)
          0: tag = "R4 sweep"; 1: tag = "R5 sweep"; 2: tag = "R6 sweep";
          3: tag = "R7 sweep"; 4, 5: tag = "R8 sweep"; default: tag = "R12 sweep";
        endcase
        len = (nv == 0) ? 220 : 4 * int'(nv) + 14;
        drive(0, 1, 1, nv, 3'(code), tag);
        for (int k = 0; k < len; k++)
          drive((k % 3) != 2, (k % 19) < 16, 0, 16'd0, 3'(code), tag);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule